// File: doc/BRIEF.md
# ADC Result Register with Overrun Handling and DMA Request Control

This block sits behind an analog-to-digital conversion sequencer and owns the single result register that software or a DMA engine reads. Each completed conversion arrives as a one-cycle pulse with its data word. The block then raises an end-of-conversion flag and detects when a result is about to be lost because the previous one was never read. A configuration bit picks what happens to the register on such an overrun: it either keeps the unread older result or takes the newest one.

When DMA is enabled, every conversion raises a request that a DMA acknowledge or a CPU read retires. After an overrun the block stops requesting until software clears the overrun flag. Five sticky event flags, one of them the overrun flag, are each masked by their own enable and merged into one registered interrupt line.

Top module: `adc_result_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it, `result` is 0 and `eoc`, `flags`, `dma_req` and `irq` are all 0.
- R2: A `conv_done` pulse sets `eoc` in the next cycle. Unless it overruns, `result` then holds that cycle's `conv_data`.
- R3: A `cpu_rd` or `dma_ack` in a cycle without `conv_done` clears `eoc` and `dma_req` in the next cycle. A read in the same cycle as `conv_done` consumes the old result, so no overrun occurs.
- R4: An overrun is `conv_done` while `eoc` is 1 and neither `cpu_rd` nor `dma_ack` is high. It sets `flags[3]` in the next cycle.
- R5: With `ovr_overwrite` = 0, an overrunning conversion leaves `result` unchanged.
- R6: With `ovr_overwrite` = 1, an overrunning conversion replaces `result` with the new data.
- R7: With `dma_en` = 1 and `flags[3]` = 0, `conv_done` raises `dma_req` in the next cycle. With `dma_en` = 0, `dma_req` is 0 in the next cycle.
- R8: An overrun drops `dma_req`. While `flags[3]` is 1 no new request is raised. After the flag is cleared, the next conversion requests again.
- R9: Flag bit positions are: 0 end of sequence (`seq_end_evt`), 1 end of sampling (`smp_end_evt`), 2 ready (`ready_evt`), 3 overrun, 4 analog watchdog (`wdog_evt`). Flags are sticky. A 1 in `flag_clr[i]` clears bit i in the next cycle, but a set in the same cycle wins.
- R10: `irq` in a cycle equals the OR of (`flags` AND `irq_en`) from the cycle before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_done | input | 1 | One-cycle pulse per finished conversion |
| conv_data | input | DW | Data of the finished conversion |
| ovr_overwrite | input | 1 | 1: newest result replaces on overrun; 0: old result kept |
| dma_en | input | 1 | Enables DMA requests |
| cpu_rd | input | 1 | CPU read of the result register |
| dma_ack | input | 1 | DMA acknowledge (read) of the result register |
| seq_end_evt | input | 1 | End-of-sequence event pulse |
| smp_end_evt | input | 1 | End-of-sampling event pulse |
| ready_evt | input | 1 | Converter-ready event pulse |
| wdog_evt | input | 1 | Analog watchdog event pulse |
| flag_clr | input | 5 | Write-1-to-clear strobes, one per flag |
| irq_en | input | 5 | Interrupt enable, one per flag |
| result | output | DW | Result register |
| eoc | output | 1 | End-of-conversion flag |
| flags | output | 5 | Sticky event flags |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | Registered interrupt |

## Verification
Conversion streams are driven in three ways: read before the next conversion, read in the same cycle as the next conversion, and not read at all. These separate a normal hand-off, a consumed-in-time result and a true overrun. Each overrun case runs with the overwrite bit both low and high, which tells keeping the old result apart from replacing it. The DMA streams acknowledge in time, miss an acknowledge and keep converting while locked, then clear the flag. This shows that requests stop on overrun and come back only after the clear. Directed tests cover set-versus-clear collisions on the flags, the one-cycle interrupt lag and reset in the middle of activity.

// File: rtl/adc_result_ctrl.sv
module adc_result_ctrl #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  input  logic          ovr_overwrite,
  input  logic          dma_en,
  input  logic          cpu_rd,
  input  logic          dma_ack,
  input  logic          seq_end_evt,
  input  logic          smp_end_evt,
  input  logic          ready_evt,
  input  logic          wdog_evt,
  input  logic [4:0]    flag_clr,
  input  logic [4:0]    irq_en,
  output logic [DW-1:0] result,
  output logic          eoc,
  output logic [4:0]    flags,
  output logic          dma_req,
  output logic          irq
);
  localparam int F_OVR = 3;

  logic       consumed, ovr_evt, take;
  logic [4:0] set_vec;

  assign consumed = cpu_rd | dma_ack;
  assign ovr_evt  = conv_done & eoc & ~consumed;
  assign take     = conv_done & (~ovr_evt | ovr_overwrite);
  assign set_vec  = {wdog_evt, ovr_evt, ready_evt, smp_end_evt, seq_end_evt};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result  <= '0;
      eoc     <= 1'b0;
      flags   <= '0;
      dma_req <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (take) result <= conv_data;

      if (conv_done)     eoc <= 1'b1;
      else if (consumed) eoc <= 1'b0;

      if (!dma_en || ovr_evt)                dma_req <= 1'b0;
      else if (conv_done && !flags[F_OVR])   dma_req <= 1'b1;
      else if (consumed)                     dma_req <= 1'b0;

      flags <= (flags & ~flag_clr) | set_vec;
      irq   <= |(flags & irq_en);
    end
  end
endmodule

// File: rtl/adc_result_ctrl_chk.sv
module adc_result_ctrl_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_done,
  input logic [DW-1:0] conv_data,
  input logic          ovr_overwrite,
  input logic          dma_en,
  input logic          cpu_rd,
  input logic          dma_ack,
  input logic          seq_end_evt,
  input logic [4:0]    flag_clr,
  input logic [4:0]    irq_en,
  input logic [DW-1:0] result,
  input logic          eoc,
  input logic [4:0]    flags,
  input logic          dma_req,
  input logic          irq
);
  AST_EOC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> eoc); // R2
  AST_OVR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && eoc && !cpu_rd && !dma_ack) |=> flags[3]); // R4
  AST_HOLD_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && eoc && !cpu_rd && !dma_ack && !ovr_overwrite) |=> result == $past(result)); // R5
  AST_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && ovr_overwrite) |=> result == $past(conv_data)); // R6
  AST_NO_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !dma_req); // R7
  AST_DMA_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    flags[3] |=> !$rose(dma_req)); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr))); // R9
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    seq_end_evt |=> flags[0]); // R9
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 5'b0) |=> !irq); // R10
endmodule

bind adc_result_ctrl adc_result_ctrl_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
  .ovr_overwrite(ovr_overwrite), .dma_en(dma_en), .cpu_rd(cpu_rd),
  .dma_ack(dma_ack), .seq_end_evt(seq_end_evt), .flag_clr(flag_clr),
  .irq_en(irq_en), .result(result), .eoc(eoc), .flags(flags),
  .dma_req(dma_req), .irq(irq)
);

// File: tb/test_adc_result_ctrl.sv
`timescale 1ns/1ps
module test_adc_result_ctrl;
  localparam int DW = 16;
  localparam int NV = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          conv_done = 1'b0, ovr_overwrite = 1'b0, dma_en = 1'b0;
  logic          cpu_rd = 1'b0, dma_ack = 1'b0;
  logic          seq_end_evt = 1'b0, smp_end_evt = 1'b0, ready_evt = 1'b0, wdog_evt = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic [4:0]    flag_clr = '0, irq_en = '0;
  logic [DW-1:0] result;
  logic          eoc, dma_req, irq;
  logic [4:0]    flags;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_result_ctrl #(.DW(DW)) i_adc_result_ctrl (
    .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
    .ovr_overwrite(ovr_overwrite), .dma_en(dma_en), .cpu_rd(cpu_rd),
    .dma_ack(dma_ack), .seq_end_evt(seq_end_evt), .smp_end_evt(smp_end_evt),
    .ready_evt(ready_evt), .wdog_evt(wdog_evt), .flag_clr(flag_clr),
    .irq_en(irq_en), .result(result), .eoc(eoc), .flags(flags),
    .dma_req(dma_req), .irq(irq)
  );

  // {conv_done, cpu_rd, dma_ack, ovr_overwrite, dma_en, clr_ovr, data, exp_result, exp_eoc, exp_ovr, exp_req}
  localparam logic [40:0] VEC [NV] = '{
    {6'b100000, 16'h00A1, 16'h00A1, 3'b100},
    {6'b010000, 16'h0000, 16'h00A1, 3'b000},
    {6'b100000, 16'h00B2, 16'h00B2, 3'b100},
    {6'b100000, 16'h00C3, 16'h00B2, 3'b110},
    {6'b000001, 16'h0000, 16'h00B2, 3'b100},
    {6'b110000, 16'h00D4, 16'h00D4, 3'b100},
    {6'b100100, 16'h00E5, 16'h00E5, 3'b110},
    {6'b010001, 16'h0000, 16'h00E5, 3'b000},
    {6'b100010, 16'h1111, 16'h1111, 3'b101},
    {6'b001010, 16'h0000, 16'h1111, 3'b000},
    {6'b100010, 16'h2222, 16'h2222, 3'b101},
    {6'b100010, 16'h3333, 16'h2222, 3'b110},
    {6'b100010, 16'h4444, 16'h2222, 3'b110},
    {6'b010011, 16'h0000, 16'h2222, 3'b000},
    {6'b100010, 16'h5555, 16'h5555, 3'b101},
    {6'b001010, 16'h0000, 16'h5555, 3'b000},
    {6'b100000, 16'h6666, 16'h6666, 3'b100},
    {6'b010000, 16'h0000, 16'h6666, 3'b000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    conv_done = 1'b0; cpu_rd = 1'b0; dma_ack = 1'b0; flag_clr = '0;
    seq_end_evt = 1'b0; smp_end_evt = 1'b0; ready_evt = 1'b0; wdog_evt = 1'b0;
  endtask

  // inputs are driven right after a falling edge; outputs are read at the next falling edge
  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk_zero(input string tag);
    chk({tag, " result"}, 32'(result), 0);
    chk({tag, " eoc"}, 32'(eoc), 0);
    chk({tag, " flags"}, 32'(flags), 0);
    chk({tag, " dma_req"}, 32'(dma_req), 0);
    chk({tag, " irq"}, 32'(irq), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    chk_zero("R1 in reset");
    rst_n = 1'b1;
    step();
    chk_zero("R1 after reset");

    for (int i = 0; i < NV; i++) begin
      conv_done     = VEC[i][40];
      cpu_rd        = VEC[i][39];
      dma_ack       = VEC[i][38];
      ovr_overwrite = VEC[i][37];
      dma_en        = VEC[i][36];
      flag_clr      = {1'b0, VEC[i][35], 3'b000};
      conv_data     = VEC[i][34:19];
      step();
      chk($sformatf("R2/R5/R6 result step %0d", i), 32'(result), 32'(VEC[i][18:3]));
      chk($sformatf("R2/R3 eoc step %0d", i), 32'(eoc), 32'(VEC[i][2]));
      chk($sformatf("R4 ovr flag step %0d", i), 32'(flags[3]), 32'(VEC[i][1]));
      chk($sformatf("R7/R8 dma_req step %0d", i), 32'(dma_req), 32'(VEC[i][0]));
    end
    idle(); ovr_overwrite = 1'b0; dma_en = 1'b0;
    step();

    // R9: set, sticky, set wins over clear, clear
    seq_end_evt = 1'b1; step(); idle();
    chk("R9 seq flag set", 32'(flags), 32'h01);
    step();
    chk("R9 seq flag sticky", 32'(flags), 32'h01);
    seq_end_evt = 1'b1; flag_clr = 5'b00001; step(); idle();
    chk("R9 set wins over clear", 32'(flags), 32'h01);
    flag_clr = 5'b00001; step(); idle();
    chk("R9 clear", 32'(flags), 32'h00);
    smp_end_evt = 1'b1; ready_evt = 1'b1; wdog_evt = 1'b1; seq_end_evt = 1'b1;
    step(); idle();
    chk("R9 bit positions", 32'(flags), 32'h17);
    chk("R10 irq masked", 32'(irq), 0);

    // R10: one-cycle registered interrupt
    irq_en = 5'b00100; step();
    chk("R10 irq rises", 32'(irq), 1);
    flag_clr = 5'b11111; step(); idle();
    chk("R9 clear all", 32'(flags), 0);
    chk("R10 irq lags clear", 32'(irq), 1);
    step();
    chk("R10 irq falls", 32'(irq), 0);

    // R4/R10: overrun raises interrupt through its enable
    irq_en = 5'b01000;
    conv_done = 1'b1; conv_data = 16'h0777; step();
    conv_data = 16'h0888; step(); idle();
    chk("R4 overrun flag", 32'(flags), 32'h08);
    step();
    chk("R10 overrun irq", 32'(irq), 1);

    // R1: reset mid-activity
    seq_end_evt = 1'b1; dma_en = 1'b1; conv_done = 1'b1; conv_data = 16'h0999;
    rst_n = 1'b0; step(); idle();
    chk_zero("R1 mid-run reset");
    rst_n = 1'b1; irq_en = '0; dma_en = 1'b0;
    step();
    chk_zero("R1 released");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule